// File: doc/BRIEF.md
# Frame Alignment Search and Monitor

This block sits at the front of a received serial video bitstream. The stream is divided into fixed frames of 512 bits. The first bit of each frame carries one bit of an 8-bit framing sequence, `00011011`, which is sent left to right and one bit per frame. The block checks every bit phase of the frame at once. It declares frame lock when one phase has carried the sequence without a break for three full repeats. While locked, it checks every framing bit and drops lock only after a confirmed error. It strips framing, fill-indicator and parity bits, and passes only payload bits to its output.

Input bits and output bits move over valid/ready handshakes. An input bit transfers on a clock edge where `in_valid` and `in_ready` are both high. An output bit transfers on a clock edge where `out_valid` and `out_ready` are both high. There is one output holding register, and `in_ready` is high when that register is empty or is being emptied in the same cycle. A stalled output therefore pushes back on the input straight away and loses no bit. Lock, lock-lost, event and frame-count signals are plain status outputs.

When framing is switched off, the stream is treated as raw data. Lock is reported and every input bit passes through.

Top module: `frame_aligner`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold their values.
- R2: Frame layout, counting positions from 0 at the framing bit:
  - position 0 is the framing bit;
  - position 1 is the fill indicator;
  - positions 2 to 493 are payload;
  - positions 494 to 511 are the 18 parity bits.
  
  While locked, only payload bits of frames whose fill indicator is 1 are output, in arrival order. No other bit is ever output.
- R3: The framing sequence is `00011011`, one bit per frame. Lock is found whatever the bit phase of the frames and whichever sequence bit comes first.
- R4: Lock is declared on the edge that accepts the framing bit completing 24 consecutive correct frames (three repeats) at one phase. `frame_locked` is high from the next cycle and is never high earlier in the search. No output is produced while searching.
- R5: While locked, a single wrong framing bit that is followed by four correct ones does not drop lock. After those four, a new error starts a fresh check window.
- R6: While locked, a framing error followed by another error within the next four framing bits drops lock on the edge that accepts the second error. The search then restarts with empty history, so relock needs 24 new frames.
- R7: `lock_lost` is set when lock drops and cleared when lock is next declared. `lock_event` is a one-cycle pulse after each lock and each loss, and is low at every other framing bit.
- R8: `locked_frames` clears when lock is declared. It increments on each accepted framing bit while locked, except the bit that drops lock. It saturates at 2^CNT_W-1.
- R9: While `framing_en` is low, `frame_locked` is high and every accepted bit is output in order. Raising `framing_en` restarts the search, with `frame_locked` low from the next cycle.
- R10: After reset:
  - `frame_locked`, `lock_lost` and `lock_event` are low;
  - `locked_frames` is 0;
  - `out_valid` is low;
  - `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| framing_en | input | 1 | 1: frame search and monitor; 0: raw pass-through |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Received stream bit |
| out_valid | output | 1 | Output holds a payload bit |
| out_ready | input | 1 | Downstream takes the output bit |
| out_bit | output | 1 | Payload bit |
| frame_locked | output | 1 | Frame lock held (always high in pass-through) |
| lock_lost | output | 1 | Lock dropped since last lock |
| lock_event | output | 1 | One-cycle pulse on lock or loss |
| locked_frames | output | CNT_W | Saturating count of frames while locked |

## Verification
Lock, loss, event and frame-count results are due in the cycle after the edge that accepts the deciding framing bit. The bench therefore waits for that edge after every framing bit and samples 1 ns later. An accepted payload bit is valid at the output in the cycle after its accepting edge, while `in_ready` responds within the same cycle. For this reason, inputs are driven at the falling edge and the ready rule and output transfers are read 1 ns after that, before the next rising edge. Expected payload bits go into a queue when their input bit is accepted and are compared in order as each output transfer happens.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef enum logic [1:0] {
    ST_BYP  = 2'd0,
    ST_SRCH = 2'd1,
    ST_LOCK = 2'd2
  } fa_state_e;

  typedef enum logic [1:0] {
    POS_SYNC   = 2'd0,
    POS_FILL   = 2'd1,
    POS_DATA   = 2'd2,
    POS_PARITY = 2'd3
  } fa_pos_e;

endpackage

// File: rtl/fa_search.sv
module fa_search #(
  parameter int FRAME_LEN = 512,
  parameter int PAT_W     = 8,
  parameter logic [PAT_W-1:0] PATTERN = 8'b00011011,
  parameter int LOCK_WIN  = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic                         step,
  input  logic                         bit_i,
  input  logic [$clog2(FRAME_LEN)-1:0] addr,
  output logic                         found,
  output logic [PAT_W-1:0]             found_hist
);
  localparam int AW = $clog2(FRAME_LEN);
  localparam int SW = $clog2(PAT_W + 1);
  localparam int RW = $clog2(LOCK_WIN + 1);
  localparam int FW = $clog2(FRAME_LEN + 1);
  localparam logic [SW-1:0] SEEN_FULL = SW'(PAT_W);
  localparam logic [RW-1:0] RUN_FULL  = RW'(LOCK_WIN);
  localparam logic [FW-1:0] SWEEP_ALL = FW'(FRAME_LEN);

  // per-phase history: last PAT_W framing candidates, bits seen, consistent run
  logic [PAT_W-1:0] hist_mem [FRAME_LEN];
  logic [SW-1:0]    seen_mem [FRAME_LEN];
  logic [RW-1:0]    run_mem  [FRAME_LEN];

  logic [FW-1:0]    sweep_left;
  logic             fresh;
  logic [PAT_W-1:0] h_old, h_new;
  logic [SW-1:0]    s_old, s_new;
  logic [RW-1:0]    r_old, r_new;
  logic [PAT_W-1:0] rot_hit;
  logic             rot, cont;
  logic [AW-1:0]    a_q;

  assign a_q   = addr;
  // first visit of every phase after a restart reads as empty history
  assign fresh = (sweep_left != '0);
  assign h_old = fresh ? '0 : hist_mem[a_q];
  assign s_old = fresh ? '0 : seen_mem[a_q];
  assign r_old = fresh ? '0 : run_mem[a_q];
  assign h_new = {h_old[PAT_W-2:0], bit_i};
  assign s_new = (s_old == SEEN_FULL) ? s_old : s_old + 1'b1;

  for (genvar k = 0; k < PAT_W; k++) begin : g_rot
    localparam logic [PAT_W-1:0] ROT =
      (k == 0) ? PATTERN : ((PATTERN << k) | (PATTERN >> (PAT_W - k)));
    assign rot_hit[k] = (h_new == ROT);
  end

  assign rot  = (s_new == SEEN_FULL) && (|rot_hit);
  // a running match continues only if the new bit repeats the one a period ago
  assign cont = (r_old != '0) && (bit_i == h_old[PAT_W-1]);

  always_comb begin
    if (!rot)                  r_new = '0;
    else if (!cont)            r_new = RW'(1);
    else if (r_old == RUN_FULL) r_new = r_old;
    else                       r_new = r_old + 1'b1;
  end

  assign found      = step && rot && (r_new == RUN_FULL);
  assign found_hist = h_new;

  always_ff @(posedge clk) begin
    if (step) begin
      hist_mem[a_q] <= h_new;
      seen_mem[a_q] <= s_new;
      run_mem[a_q]  <= r_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) sweep_left <= SWEEP_ALL;
    else if (step && fresh) sweep_left <= sweep_left - 1'b1;
  end

  // R4: a lock cannot complete inside the first sweep after a restart
  a_r4_no_lock_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !fresh);

endmodule

// File: rtl/fa_monitor.sv
module fa_monitor
  import fa_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int PAT_W     = 8,
  parameter int CONFIRM   = 4,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         framing_en,
  input  logic                         acc,
  input  logic                         bit_i,
  input  logic                         found,
  input  logic [PAT_W-1:0]             found_hist,
  output logic [$clog2(FRAME_LEN)-1:0] ph,
  output fa_state_e                    st,
  output logic                         restart,
  output logic                         lock_o,
  output logic                         lost_o,
  output logic                         event_o,
  output logic [CNT_W-1:0]             frame_cnt
);
  localparam int AW = $clog2(FRAME_LEN);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [AW-1:0]    PH_LAST  = AW'(FRAME_LEN - 1);
  localparam logic [CW-1:0]    CONF_ALL = CW'(CONFIRM);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [PAT_W-1:0] exp_win;
  logic [CW-1:0]    conf;
  logic             fb, err, confirming, drop;

  assign fb         = (st == ST_LOCK) && acc && (ph == '0);
  assign err        = (bit_i != exp_win[PAT_W-1]);
  assign confirming = (conf != '0);
  assign drop       = fb && err && confirming;
  assign restart    = framing_en && ((st == ST_BYP) || drop);
  assign lock_o     = (st != ST_SRCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_SRCH;
      ph        <= '0;
      exp_win   <= '0;
      conf      <= '0;
      frame_cnt <= '0;
      lost_o    <= 1'b0;
      event_o   <= 1'b0;
    end else begin
      event_o <= 1'b0;
      if (acc) begin
        if (st == ST_SRCH && found) ph <= AW'(1);
        else if (ph == PH_LAST)     ph <= '0;
        else                        ph <= ph + 1'b1;
      end
      if (!framing_en) begin
        st <= ST_BYP;
      end else begin
        unique case (st)
          ST_BYP:  st <= ST_SRCH;
          ST_SRCH: if (found) begin
            st        <= ST_LOCK;
            exp_win   <= found_hist;
            conf      <= '0;
            frame_cnt <= '0;
            lost_o    <= 1'b0;
            event_o   <= 1'b1;
          end
          ST_LOCK: if (fb) begin
            exp_win <= {exp_win[PAT_W-2:0], exp_win[PAT_W-1]};
            if (drop) begin
              st      <= ST_SRCH;
              conf    <= '0;
              lost_o  <= 1'b1;
              event_o <= 1'b1;
            end else begin
              if (frame_cnt != CNT_MAX) frame_cnt <= frame_cnt + 1'b1;
              if (err)             conf <= CONF_ALL;
              else if (confirming) conf <= conf - 1'b1;
            end
          end
          default: st <= ST_SRCH;
        endcase
      end
    end
  end

  a_r5_lone_error_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fb && err && !confirming && framing_en) |=> (st == ST_LOCK));

  a_r6_confirmed_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && framing_en) |=> (!lock_o && lost_o && event_o));

  a_r7_lock_event: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SRCH && framing_en && found) |=> (event_o && lock_o && !lost_o));

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK && frame_cnt == CNT_MAX && framing_en)
      |=> (st != ST_LOCK || frame_cnt == CNT_MAX));

  a_r9_bypass_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !framing_en |=> lock_o);

endmodule

// File: rtl/fa_slicer.sv
module fa_slicer
  import fa_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int PAR_BITS  = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc,
  input  logic                         bit_i,
  input  logic [$clog2(FRAME_LEN)-1:0] ph,
  input  logic                         bypass,
  input  logic                         locked,
  input  logic                         out_ready,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic                         out_bit
);
  localparam int AW = $clog2(FRAME_LEN);
  localparam logic [AW-1:0] FILL_POS   = AW'(1);
  localparam logic [AW-1:0] PARITY_POS = AW'(FRAME_LEN - PAR_BITS);

  fa_pos_e kind;
  logic    fill_q, take;

  always_comb begin
    if (ph == '0)               kind = POS_SYNC;
    else if (ph == FILL_POS)    kind = POS_FILL;
    else if (ph < PARITY_POS)   kind = POS_DATA;
    else                        kind = POS_PARITY;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = acc && (bypass || (locked && kind == POS_DATA && fill_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q    <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (acc && locked && kind == POS_FILL) fill_q <= bit_i;
      if (take) begin
        out_valid <= 1'b1;
        out_bit   <= bit_i;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  a_r2_only_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bypass && kind != POS_DATA) |=> !out_valid);

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int PAR_BITS  = 18,
  parameter int PAT_W     = 8,
  parameter logic [PAT_W-1:0] PATTERN = 8'b00011011,
  parameter int REPEATS   = 3,
  parameter int CONFIRM   = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             framing_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             frame_locked,
  output logic             lock_lost,
  output logic             lock_event,
  output logic [CNT_W-1:0] locked_frames
);
  localparam int AW       = $clog2(FRAME_LEN);
  localparam int LOCK_WIN = REPEATS * PAT_W - PAT_W + 1;

  logic             acc, step, found, restart;
  logic [PAT_W-1:0] found_hist;
  logic [AW-1:0]    ph;
  fa_state_e        st;

  assign acc  = in_valid && in_ready;
  assign step = acc && (st == ST_SRCH);

  fa_search #(
    .FRAME_LEN(FRAME_LEN), .PAT_W(PAT_W), .PATTERN(PATTERN), .LOCK_WIN(LOCK_WIN)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step), .bit_i(in_bit),
    .addr(ph), .found(found), .found_hist(found_hist)
  );

  fa_monitor #(
    .FRAME_LEN(FRAME_LEN), .PAT_W(PAT_W), .CONFIRM(CONFIRM), .CNT_W(CNT_W)
  ) u_monitor (
    .clk(clk), .rst_n(rst_n), .framing_en(framing_en), .acc(acc), .bit_i(in_bit),
    .found(found), .found_hist(found_hist), .ph(ph), .st(st), .restart(restart),
    .lock_o(frame_locked), .lost_o(lock_lost), .event_o(lock_event),
    .frame_cnt(locked_frames)
  );

  fa_slicer #(
    .FRAME_LEN(FRAME_LEN), .PAR_BITS(PAR_BITS)
  ) u_slicer (
    .clk(clk), .rst_n(rst_n), .acc(acc), .bit_i(in_bit), .ph(ph),
    .bypass(st == ST_BYP), .locked(st == ST_LOCK), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit)
  );

  // R4: output never starts while the search is running
  a_r4_quiet_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> frame_locked);

endmodule

// File: tb/sim_frame_aligner.sv
module sim_frame_aligner;
  localparam int FL = 512;
  localparam int CW = 5;
  localparam logic [7:0] PAT = 8'b00011011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic framing_en = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, frame_locked, lock_lost, lock_event;
  logic [CW-1:0] locked_frames;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit m_locked = 0;
  bit m_lost = 0;
  bit m_byp = 0;
  int m_run = 0;
  int m_conf = 0;
  int m_cnt = 0;
  int pat_idx = 0;
  string tag = "R4";

  always #5 clk = ~clk;

  frame_aligner #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .framing_en(framing_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .frame_locked(frame_locked),
    .lock_lost(lock_lost), .lock_event(lock_event), .locked_frames(locked_frames)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_pop();
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected output bit", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(out_bit == e, m_byp ? "R9 pass-through bit" : "R2 payload bit", out_bit, e);
      end
    end
  endtask

  task automatic send_bit(input bit b, input bit push);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid  = (($urandom % 8) != 0);
      in_bit    = b;
      out_ready = (($urandom % 4) != 0);
      #1;
      do_pop();
      chk(in_ready == (!out_valid || out_ready), "R1 ready rule", in_ready, !out_valid || out_ready);
      if (in_valid && in_ready) begin
        done = 1;
        if (push) exp_q.push_back(b);
      end
    end
  endtask

  task automatic send_frame(input bit bad, input bit fill);
    bit fb;
    bit ev;
    fb = PAT[7 - pat_idx] ^ bad;
    pat_idx = (pat_idx + 1) % 8;
    send_bit(fb, m_byp);
    @(posedge clk); #1;
    ev = 0;
    if (m_locked) begin
      if (bad && m_conf > 0) begin
        m_locked = 0; m_lost = 1; m_run = 0; m_conf = 0; ev = 1;
      end else begin
        if (m_cnt < (1 << CW) - 1) m_cnt++;
        if (bad) m_conf = 4;
        else if (m_conf > 0) m_conf--;
      end
    end else begin
      m_run++;
      if (m_run == 24) begin
        m_locked = 1; m_lost = 0; m_cnt = 0; m_conf = 0; ev = 1;
      end
    end
    chk(frame_locked == m_locked, {tag, " lock state"}, frame_locked, m_locked);
    chk(lock_lost == m_lost, "R7 lost flag", lock_lost, m_lost);
    chk(lock_event == ev, "R7 event pulse", lock_event, ev);
    if (m_locked) chk(locked_frames == m_cnt, "R8 frame count", locked_frames, m_cnt);
    for (int pos = 1; pos < FL; pos++) begin
      bit b;
      b = (pos == 1) ? fill : bit'($urandom % 2);
      send_bit(b, m_locked && fill && pos >= 2 && pos < FL - 18);
    end
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    in_valid   = 0;
    out_ready  = 1;
    framing_en = v;
    #1;
    do_pop();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int junk;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1, "R10 in_ready", in_ready, 1);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(frame_locked == 0, "R10 lock", frame_locked, 0);
    chk(lock_lost == 0, "R10 lost", lock_lost, 0);
    chk(lock_event == 0, "R10 event", lock_event, 0);
    chk(locked_frames == 0, "R10 count", locked_frames, 0);
    @(negedge clk);
    rst_n = 1;

    // R3: random bit phase and random starting point of the sequence
    junk = 1 + int'($urandom % (FL - 1));
    pat_idx = int'($urandom % 8);
    for (int i = 0; i < junk; i++) send_bit(bit'($urandom % 2), 0);
    tag = "R3 R4";
    for (int f = 0; f < 24; f++) send_frame(0, ($urandom % 4) != 0);

    tag = "R8";
    for (int f = 0; f < 10; f++) send_frame(0, ($urandom % 4) != 0);

    // R5: lone errors, the second one right after the window closes
    tag = "R5";
    send_frame(1, 1);
    for (int f = 0; f < 4; f++) send_frame(0, 1);
    send_frame(1, 0);
    for (int f = 0; f < 4; f++) send_frame(0, 1);

    tag = "R8";
    for (int f = 0; f < 20; f++) send_frame(0, ($urandom % 4) != 0);

    // R6: second error on the fourth framing bit of the window
    tag = "R6";
    send_frame(1, 1);
    for (int f = 0; f < 3; f++) send_frame(0, 1);
    send_frame(1, 1);

    tag = "R6 R4";
    for (int f = 0; f < 24; f++) send_frame(0, ($urandom % 4) != 0);
    tag = "R8";
    for (int f = 0; f < 2; f++) send_frame(0, 1);

    // R9: raw pass-through
    set_en(0);
    m_byp = 1;
    chk(frame_locked == 1, "R9 bypass lock", frame_locked, 1);
    for (int i = 0; i < 300; i++) send_bit(bit'($urandom % 2), 1);
    set_en(1);
    m_byp = 0;
    chk(frame_locked == 0, "R9 search after enable", frame_locked, 0);
    for (int i = 0; i < 100; i++) send_bit(bit'($urandom % 2), 0);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid  = 0;
      out_ready = 1;
      #1;
      do_pop();
    end
    chk(exp_q.size() == 0, "R2 all payload delivered", exp_q.size(), 0);
    chk(out_valid == 0, "R9 no output while searching", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule